// File: doc/BRIEF.md
# Self-Timed Flash Operation Sequencer

This block runs erase, program and checksum operations on an on-chip flash array that also holds the processor's code. When a request is accepted, the block raises a stall output that keeps the processor idle. It then checks the security input and times the operation with its own countdown. The requester never signals completion. A program operation is followed by a read-back compare. An interrupt or a high-voltage fault ends the operation early, and the stall is released so the array can serve instruction fetches again.

When the operation ends, the block gives a one-cycle completion pulse. It also presents an error flag in the style of a carry bit and an 8-bit status byte. The status byte has four flags: interrupted, security refused, high-voltage fault and read-back mismatch. Code that allows interrupts during flash work is expected to sample the error flag after every operation and to repeat any operation that was interrupted. The array itself sits outside the block. The block reaches it through a word-wide port with a write strobe, an erase strobe and an asynchronous read path.

Top module: `flash_op_seq`

## Requirements
- R1: `stall` rises in the cycle after a request is accepted and stays high until the operation ends. A request is accepted only while the block is idle. A `req` that arrives while an operation is in progress is ignored: it starts nothing and touches no memory.
- R2: The countdown lengths are N_ERASE, N_PROG and N_CRC cycles. With no fault, `stall` is high for N_ERASE+1 cycles for an erase, N_CRC+1 cycles for a checksum and N_PROG+3 cycles for a program. If the operation is aborted in countdown cycle k, `stall` is high for k+1 cycles.
- R3: `done` pulses for exactly one cycle, and it does so one cycle after `stall` falls. From that pulse on, `status` and `carry` hold the result.
- R4: If `irq` is high during the countdown, the operation ends at that edge. `stall` falls and status bit 0 is set. Memory is not written or erased.
- R5: The security input `sec_deny` is sampled in the cycle after acceptance. If it is high, the countdown is skipped, `stall` is high for one cycle only, status bit 1 is set, memory is unchanged and `crc_valid` stays low.
- R6: If `hv_fault` is high during the countdown, the operation is aborted and status bit 2 is set. When `irq` and `hv_fault` arrive in the same cycle, only bit 0 is set.
- R7: `op` = 1 selects program. At the end of the countdown, the block pulses `mem_we` for one cycle with the latched address and data. In the next cycle it reads the location back. If the read value differs from the intended data, status bit 3 is set.
- R8: `rd_protect` is sampled when the request is accepted. A program to a protected location still writes the data, but status bit 3 is always set.
- R9: `op` = 0 selects erase. At the end of the countdown, the block pulses `mem_erase` for one cycle on the latched address, and the array then holds all ones at that location.
- R10: `op` = 2 or 3 selects a checksum. The block reads N_CRC consecutive words starting at `addr`, with the address wrapping modulo 2^AW. The result starts from all ones, and each word updates it as rotate-left-by-one, then XOR with the word. `crc_valid` is set only if no status flag is set.
- R11: Status bits 7 to 4 always read 0. After `done`, `carry` equals the OR of all status bits.
- R12: `status` and `carry` clear when a request is accepted. While the block is idle they stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Operation request, taken when idle |
| op | input | 2 | 0 erase, 1 program, 2 or 3 checksum |
| addr | input | AW | Target or start address |
| wdata | input | DW | Data to program |
| sec_deny | input | 1 | Security settings refuse the operation |
| hv_fault | input | 1 | High-voltage generator fault |
| rd_protect | input | 1 | Addressed location blocked for table reads |
| irq | input | 1 | Interrupt request, aborts the countdown |
| mem_rdata | input | DW | Array read data for `mem_addr` |
| stall | output | 1 | Holds the processor idle |
| done | output | 1 | One-cycle completion pulse |
| carry | output | 1 | Error flag, OR of status |
| status | output | 8 | Error flags in bits 3..0 |
| crc_out | output | DW | Checksum result |
| crc_valid | output | 1 | Checksum result usable |
| mem_addr | output | AW | Array address |
| mem_wdata | output | DW | Array write data |
| mem_we | output | 1 | Program strobe |
| mem_erase | output | 1 | Erase strobe |

## Verification
The assertions check on every cycle that abort causes map to the right flag and drop the stall at once. They also check that the interrupt outranks the fault, that the upper status bits stay clear, and that the error flag agrees with the status byte at each completion pulse. Finally, they check that the result is cleared on acceptance and held while idle.

Some behaviour only the bench scenarios can show:
- the exact stall lengths for each operation;
- that an aborted or refused operation leaves the array untouched;
- the read-back mismatch caused by a stuck bit or by a protected location;
- the checksum value, including address wrap;
- that a request made during an operation is dropped.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_ERASE = 2'd0,
    OP_PROG  = 2'd1,
    OP_CRC   = 2'd2,
    OP_CRC2  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_CHECK  = 3'd1,
    S_RUN    = 3'd2,
    S_VERIFY = 3'd3,
    S_DONE   = 3'd4
  } state_e;

  // flag positions inside the status byte
  localparam int FLAG_INTR   = 0;
  localparam int FLAG_SEC    = 1;
  localparam int FLAG_HV     = 2;
  localparam int FLAG_VERIFY = 3;
  localparam int NFLAGS      = 4;

endpackage

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (dec && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/flash_seq_crc.sv
module flash_seq_crc #(
  parameter int          DW   = 8,
  parameter logic [DW-1:0] INIT = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] crc
);

  logic [DW-1:0] rot;

  generate
    if (DW > 1) begin : g_rot
      assign rot = {crc[DW-2:0], crc[DW-1]};
    end else begin : g_flat
      assign rot = crc;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      crc <= INIT;
    end else if (en) begin
      crc <= rot ^ din;
    end
  end

endmodule

// File: rtl/flash_seq_status.sv
module flash_seq_status #(
  parameter int NF = 4,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [NF-1:0] set,
  output logic [SW-1:0] status
);

  generate
    for (genvar i = 0; i < SW; i++) begin : g_bit
      if (i < NF) begin : g_flag
        always_ff @(posedge clk) begin
          if (rst || clr) begin
            status[i] <= 1'b0;
          end else if (set[i]) begin
            status[i] <= 1'b1;
          end
        end
      end else begin : g_zero
        assign status[i] = 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
  import flash_seq_pkg::*;
#(
  parameter int AW      = 8,
  parameter int DW      = 8,
  parameter int N_ERASE = 6,
  parameter int N_PROG  = 4,
  parameter int N_CRC   = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [1:0]    op,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          sec_deny,
  input  logic          hv_fault,
  input  logic          rd_protect,
  input  logic          irq,
  input  logic [DW-1:0] mem_rdata,
  output logic          stall,
  output logic          done,
  output logic          carry,
  output logic [7:0]    status,
  output logic [DW-1:0] crc_out,
  output logic          crc_valid,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_erase
);

  localparam int NMAX_A = (N_ERASE > N_PROG) ? N_ERASE : N_PROG;
  localparam int NMAX   = (NMAX_A > N_CRC) ? NMAX_A : N_CRC;
  localparam int CW     = $clog2(NMAX + 1);
  localparam logic [CW-1:0] LEN_E = CW'(N_ERASE - 1);
  localparam logic [CW-1:0] LEN_P = CW'(N_PROG - 1);
  localparam logic [CW-1:0] LEN_C = CW'(N_CRC - 1);

  state_e        state;
  logic [1:0]    op_q;
  logic          prot_q;
  logic          vphase;
  logic          accept;
  logic          is_crc;
  logic          is_prog;
  logic          expired;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic [NFLAGS-1:0] flag_set;

  assign accept  = (state == S_IDLE) && req;
  assign is_crc  = op_q[1];
  assign is_prog = (op_q == OP_PROG);

  // countdown length by operation
  always_comb begin
    if (is_crc)       tmr_val = LEN_C;
    else if (is_prog) tmr_val = LEN_P;
    else              tmr_val = LEN_E;
  end

  assign tmr_load = (state == S_CHECK) && !sec_deny;

  flash_seq_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .dec      (state == S_RUN),
    .expired  (expired)
  );

  flash_seq_crc #(.DW(DW), .INIT({DW{1'b1}})) u_crc (
    .clk (clk),
    .rst (rst),
    .clr (accept),
    .en  ((state == S_RUN) && is_crc),
    .din (mem_rdata),
    .crc (crc_out)
  );

  // flag raise conditions; interrupt outranks high-voltage fault
  always_comb begin
    flag_set              = '0;
    flag_set[FLAG_INTR]   = (state == S_RUN) && irq;
    flag_set[FLAG_SEC]    = (state == S_CHECK) && sec_deny;
    flag_set[FLAG_HV]     = (state == S_RUN) && !irq && hv_fault;
    flag_set[FLAG_VERIFY] = (state == S_VERIFY) && vphase &&
                            (prot_q || (mem_rdata != mem_wdata));
  end

  flash_seq_status #(.NF(NFLAGS), .SW(8)) u_stat (
    .clk    (clk),
    .rst    (rst),
    .clr    (accept),
    .set    (flag_set),
    .status (status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      op_q      <= '0;
      prot_q    <= 1'b0;
      vphase    <= 1'b0;
      stall     <= 1'b0;
      done      <= 1'b0;
      carry     <= 1'b0;
      crc_valid <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      mem_erase <= 1'b0;
    end else begin
      done      <= 1'b0;
      mem_we    <= 1'b0;
      mem_erase <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req) begin
            state     <= S_CHECK;
            op_q      <= op;
            prot_q    <= rd_protect;
            mem_addr  <= addr;
            mem_wdata <= wdata;
            stall     <= 1'b1;
            carry     <= 1'b0;
            crc_valid <= 1'b0;
          end
        end
        S_CHECK: begin
          if (sec_deny) begin
            state <= S_DONE;
            stall <= 1'b0;
          end else begin
            state <= S_RUN;
          end
        end
        S_RUN: begin
          if (irq || hv_fault) begin
            state <= S_DONE;
            stall <= 1'b0;
          end else begin
            if (is_crc) begin
              mem_addr <= mem_addr + 1'b1;
            end
            if (expired) begin
              if (is_prog) begin
                mem_we <= 1'b1;
                vphase <= 1'b0;
                state  <= S_VERIFY;
              end else begin
                mem_erase <= !is_crc;
                state     <= S_DONE;
                stall     <= 1'b0;
              end
            end
          end
        end
        S_VERIFY: begin
          if (!vphase) begin
            vphase <= 1'b1;
          end else begin
            state <= S_DONE;
            stall <= 1'b0;
          end
        end
        S_DONE: begin
          done      <= 1'b1;
          carry     <= (status != 8'd0);
          crc_valid <= is_crc && (status == 8'd0);
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_op_seq_chk.sv
module flash_op_seq_chk
  import flash_seq_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       req,
  input logic       irq,
  input logic       hv_fault,
  input logic       sec_deny,
  input logic       stall,
  input logic       done,
  input logic       carry,
  input logic [7:0] status,
  input logic       mem_we,
  input logic       mem_erase,
  input state_e     state
);

  // R11
  a_r11_upper_zero: assert property (@(posedge clk) disable iff (rst)
    status[7:4] == 4'd0);

  // R11
  a_r11_carry_match: assert property (@(posedge clk) disable iff (rst)
    done |-> (carry == (status != 8'd0)));

  // R3
  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R1
  a_r1_stall_busy: assert property (@(posedge clk) disable iff (rst)
    (state == S_CHECK || state == S_RUN || state == S_VERIFY) |-> stall);

  // R4
  a_r4_irq_abort: assert property (@(posedge clk) disable iff (rst)
    (state == S_RUN && irq) |=> (!stall && status[0] && !mem_we && !mem_erase));

  // R5
  a_r5_sec_abort: assert property (@(posedge clk) disable iff (rst)
    (state == S_CHECK && sec_deny) |=> (!stall && status[1] && !mem_we && !mem_erase));

  // R6
  a_r6_hv_abort: assert property (@(posedge clk) disable iff (rst)
    (state == S_RUN && !irq && hv_fault) |=> (!stall && status[2] && !status[0]));

  // R12
  a_r12_clear_on_accept: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && req) |=> (status == 8'd0 && !carry && stall));

  // R12
  a_r12_stable_idle: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && !req) |=> ($stable(status) && $stable(carry)));

endmodule

bind flash_op_seq flash_op_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .req       (req),
  .irq       (irq),
  .hv_fault  (hv_fault),
  .sec_deny  (sec_deny),
  .stall     (stall),
  .done      (done),
  .carry     (carry),
  .status    (status),
  .mem_we    (mem_we),
  .mem_erase (mem_erase),
  .state     (state)
);

// File: tb/sim_flash_op_seq.sv
`timescale 1ns/1ps
module sim_flash_op_seq;

  localparam int AW = 8;
  localparam int DW = 8;
  localparam int NE = 6;
  localparam int NP = 4;
  localparam int NC = 8;
  localparam logic [7:0] STUCK_ADDR = 8'h05;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic [1:0]    op = 2'd0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          sec_deny = 1'b0;
  logic          hv_fault = 1'b0;
  logic          rd_protect;
  logic          irq = 1'b0;
  logic [DW-1:0] mem_rdata;
  logic          stall, done, carry, crc_valid, mem_we, mem_erase;
  logic [7:0]    status;
  logic [DW-1:0] crc_out, mem_wdata;
  logic [AW-1:0] mem_addr;

  logic [DW-1:0] fmem    [0:255];
  logic [DW-1:0] exp_mem [0:255];

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  flash_op_seq #(.AW(AW), .DW(DW), .N_ERASE(NE), .N_PROG(NP), .N_CRC(NC)) u0 (
    .clk(clk), .rst(rst), .req(req), .op(op), .addr(addr), .wdata(wdata),
    .sec_deny(sec_deny), .hv_fault(hv_fault), .rd_protect(rd_protect), .irq(irq),
    .mem_rdata(mem_rdata), .stall(stall), .done(done), .carry(carry),
    .status(status), .crc_out(crc_out), .crc_valid(crc_valid),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_erase(mem_erase)
  );

  function automatic logic is_prot(input logic [7:0] a);
    return a[3:0] == 4'hF;
  endfunction

  function automatic logic [7:0] stored_val(input logic [7:0] a, input logic [7:0] d);
    return (a == STUCK_ADDR) ? (d & 8'hFE) : d;
  endfunction

  function automatic logic [7:0] crc_ref(input logic [7:0] base);
    logic [7:0] c = 8'hFF;
    for (int k = 0; k < NC; k++) begin
      logic [7:0] ix = base + 8'(k);
      c = {c[6:0], c[7]} ^ exp_mem[ix];
    end
    return c;
  endfunction

  // behavioural flash array with one stuck-at-0 bit
  assign rd_protect = is_prot(addr);
  assign mem_rdata  = fmem[mem_addr];
  always @(posedge clk) begin
    if (mem_we)         fmem[mem_addr] <= stored_val(mem_addr, mem_wdata);
    else if (mem_erase) fmem[mem_addr] <= '1;
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] o, input logic [7:0] a, input logic [7:0] d,
                        input bit sec, input int irq_at, input int hv_at, input bit poke);
    int n, exp_stall, scnt, cyc;
    bit got_done;
    logic [7:0] exp_st, exp_crc, pa, pa_before;
    n = (o == 2'd0) ? NE : (o == 2'd1) ? NP : NC;
    exp_st = 8'd0;
    exp_crc = crc_ref(a);
    pa = a ^ 8'h40;
    pa_before = exp_mem[pa];
    if (sec) begin
      exp_st[1] = 1'b1; exp_stall = 1;
    end else if (irq_at > 0 && (hv_at == 0 || irq_at <= hv_at)) begin
      exp_st[0] = 1'b1; exp_stall = 1 + irq_at;
    end else if (hv_at > 0) begin
      exp_st[2] = 1'b1; exp_stall = 1 + hv_at;
    end else begin
      exp_stall = n + 1 + ((o == 2'd1) ? 2 : 0);
      if (o == 2'd0) exp_mem[a] = 8'hFF;
      if (o == 2'd1) begin
        exp_mem[a] = stored_val(a, d);
        if (is_prot(a) || exp_mem[a] != d) exp_st[3] = 1'b1;
      end
    end
    @(negedge clk);
    req = 1'b1; op = o; addr = a; wdata = d; sec_deny = sec;
    scnt = 0; cyc = 0; got_done = 1'b0;
    while (!got_done && cyc < 300) begin
      @(negedge clk);
      cyc++;
      req = 1'b0;
      if (poke && cyc == 2) begin req = 1'b1; op = 2'd0; addr = pa; end
      if (poke && cyc == 3) begin req = 1'b0; op = o; addr = a; end
      irq      = (irq_at > 0) && (cyc == irq_at + 1);
      hv_fault = (hv_at > 0) && (cyc == hv_at + 1);
      if (stall) scnt++;
      if (done) got_done = 1'b1;
    end
    irq = 1'b0; hv_fault = 1'b0; sec_deny = 1'b0;
    chk(got_done, "R3 completion pulse", 32'(got_done), 32'd1);
    chk(scnt == exp_stall, "R1/R2 stall cycles", 32'(scnt), 32'(exp_stall));
    chk(status == exp_st, "R4/R5/R6/R7/R8 status byte", 32'(status), 32'(exp_st));
    chk(carry == (exp_st != 8'd0), "R11 carry", 32'(carry), 32'(exp_st != 8'd0));
    chk(fmem[a] == exp_mem[a], "R7/R9 array content", 32'(fmem[a]), 32'(exp_mem[a]));
    if (poke)
      chk(fmem[pa] == pa_before, "R1 busy request ignored", 32'(fmem[pa]), 32'(pa_before));
    if (o[1]) begin
      chk(crc_valid == (exp_st == 8'd0), "R10 checksum valid", 32'(crc_valid), 32'(exp_st == 8'd0));
      if (exp_st == 8'd0)
        chk(crc_out == exp_crc, "R10 checksum value", 32'(crc_out), 32'(exp_crc));
    end
    @(negedge clk);
    chk(!stall && !done, "R1 nothing queued", 32'({stall, done}), 32'd0);
    chk(status == exp_st, "R12 status held while idle", 32'(status), 32'(exp_st));
  endtask

  initial begin
    #1000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int seed_sink;
    seed_sink = $urandom(32'd31337);
    for (int i = 0; i < 256; i++) begin
      fmem[i]    = 8'(i * 37) ^ 8'h5A;
      exp_mem[i] = 8'(i * 37) ^ 8'h5A;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!stall && !done, "R1 reset idle", 32'({stall, done}), 32'd0);
    chk(status == 8'd0 && !carry, "R11 reset status", 32'({carry, status}), 32'd0);

    run_op(2'd0, 8'h10, 8'h00, 1'b0, 0, 0, 1'b0);   // R9 erase
    run_op(2'd1, 8'h11, 8'h3C, 1'b0, 0, 0, 1'b0);   // R7 program
    run_op(2'd1, 8'h1F, 8'hA5, 1'b0, 0, 0, 1'b0);   // R8 protected location
    run_op(2'd1, 8'h05, 8'h01, 1'b0, 0, 0, 1'b0);   // R7 stuck bit mismatch
    run_op(2'd1, 8'h05, 8'h02, 1'b0, 0, 0, 1'b0);   // R7 no mismatch
    run_op(2'd2, 8'h10, 8'h00, 1'b0, 0, 0, 1'b0);   // R10 checksum
    run_op(2'd3, 8'hFC, 8'h00, 1'b0, 0, 0, 1'b0);   // R10 wrap, alternate code
    run_op(2'd1, 8'h20, 8'h77, 1'b1, 0, 0, 1'b0);   // R5 refused program
    run_op(2'd2, 8'h30, 8'h00, 1'b1, 0, 0, 1'b0);   // R5 refused checksum
    run_op(2'd1, 8'h21, 8'h12, 1'b0, 1, 0, 1'b0);   // R4 first cycle
    run_op(2'd0, 8'h22, 8'h00, 1'b0, NE, 0, 1'b0);  // R4 last cycle
    run_op(2'd2, 8'h40, 8'h00, 1'b0, 0, 2, 1'b0);   // R6 fault
    run_op(2'd0, 8'h23, 8'h00, 1'b0, 3, 3, 1'b0);   // R6 same-cycle priority
    run_op(2'd1, 8'h24, 8'h00, 1'b0, 3, 1, 1'b0);   // R6 fault before irq
    run_op(2'd1, 8'h25, 8'h9C, 1'b0, 0, 0, 1'b1);   // R1 busy request

    for (int t = 0; t < 80; t++) begin
      logic [1:0] o;
      logic [7:0] a;
      int n, r, ia, ha;
      bit s;
      o = 2'($urandom_range(0, 3));
      case ($urandom_range(0, 3))
        0: a = STUCK_ADDR;
        1: a = {4'($urandom_range(0, 15)), 4'hF};
        default: a = 8'($urandom_range(0, 255));
      endcase
      n = (o == 2'd0) ? NE : (o == 2'd1) ? NP : NC;
      r = $urandom_range(0, 7);
      s = (r == 0);
      ia = (r == 1 || r == 3) ? $urandom_range(1, n) : 0;
      ha = (r == 2 || r == 3) ? $urandom_range(1, n) : 0;
      run_op(o, a, 8'($urandom_range(0, 255)), s, ia, ha, (r == 4) && !s);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule